// File: doc/BRIEF.md
# Address Match Trigger Comparator

This block compares a bank of hardware debug triggers against the instruction stream and the data accesses of a processor core. Each trigger has three words from the trigger register bank: a control word (trigger kind, privilege enables, operation enables, window size), a compare address, and a context word that can restrict the trigger to one value of the machine context register. Every cycle the block checks the current fetch address, when its valid strobe is high, and the current load or store address against every armed trigger. It also applies the privilege level and the virtualisation flag of the hart.

When at least one trigger hits, the block raises a one-cycle breakpoint request on the next clock edge. It reports the index of the lowest-numbered trigger that hit and the faulting address. An execute hit is reported before the instruction runs, with the fetch address. A data hit is reported with the access address. Two trigger kinds are understood. The older kind is muted in virtualised modes. The newer kind has its own enables for virtual user and virtual supervisor modes.

Top module: `amt_trigger_match`

## Requirements
- R1: A trigger can fire only when its kind field (control bits [31:28]) holds 2 (basic kind) or 6 (extended kind); every other kind value never fires.
- R2: Outside virtualised mode, a trigger of either kind is enabled for privilege level p (user 0, supervisor 1, machine 3) only when control bit 3+p is set (user bit 3, supervisor bit 4, machine bit 6); level 2 never matches in the sweep, since bit 5 is left clear.
- R3: A basic-kind trigger never fires while the virtualisation flag is high, whatever its enable bits.
- R4: An extended-kind trigger in virtualised mode is enabled only by control bit 23+p (virtual user bit 23, virtual supervisor bit 24); its non-virtual bits have no effect there.
- R5: An execute hit needs control bit 2, the fetch valid strobe, and a fetch address exactly equal to the compare address; the reported address is the fetch address.
- R6: A load hit needs control bit 0 and the load strobe; a store hit needs control bit 1 and the store strobe; a trigger with no operation bit set never fires.
- R7: A data access of 2^size bytes (size 0..2) hits when any of its bytes lies in the window that starts at the compare address. The window width comes from the size code: bits [17:16] for the basic kind, bits [19:16] for the extended kind. Code 1 gives 1 byte, code 2 gives 2 bytes, code 3 gives 4 bytes, and any other code gives the 4-byte word default.
- R8: Context word bits [2:0] select the context qualifier. When bit 2 is set, the trigger fires only if context word bits [3+:CTX_W] equal the machine context input. When bit 2 is clear, no context check is made.
- R9: When several triggers hit in one cycle, the lowest index is reported. Within that trigger an execute hit takes precedence over a data hit, so the fetch address is reported.
- R10: Outputs are registered: a hit on the inputs of one cycle shows on the outputs after the next rising edge. The request lasts one cycle per strobe, and synchronous reset clears the request, index and address to zero even if the inputs hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_ctrl | input | NUM_TRIG*32 | Control words, trigger i in bits [32i+:32] |
| trig_cmp | input | NUM_TRIG*XLEN | Compare addresses, trigger i in bits [XLEN*i+:XLEN] |
| trig_ctx | input | NUM_TRIG*32 | Context qualifier words, trigger i in bits [32i+:32] |
| mctx | input | CTX_W | Machine context register value |
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Hart is in a virtualised mode |
| fetch_pc | input | XLEN | Fetch address |
| fetch_vld | input | 1 | Fetch address valid this cycle |
| mem_addr | input | XLEN | Data access address |
| mem_ld | input | 1 | Load access this cycle |
| mem_st | input | 1 | Store access this cycle |
| mem_size | input | 2 | Access size as log2 of bytes |
| bp_req | output | 1 | Breakpoint request pulse |
| bp_idx | output | IDX_W | Index of the reported trigger |
| bp_addr | output | XLEN | Faulting address |

## Verification
The hardest cases to reach are the ones where a trigger looks armed but must stay silent. Examples are an extended-kind trigger whose only enable is a non-virtual bit while the hart runs virtualised, and a basic-kind trigger with every enable set in a virtual mode. The bench reaches them with a full sweep over kind, virtualisation flag, privilege level, all 32 combinations of the five privilege enables, all eight operation masks and all three access types. A second sweep moves an access of each size across every byte offset around the window edges for every size code, and the expected overlap is computed as integer interval arithmetic.

// File: rtl/amt_pkg.sv
`timescale 1ns/1ps
package amt_pkg;
  localparam int CW        = 32;
  localparam int OP_LD     = 0;
  localparam int OP_ST     = 1;
  localparam int OP_EX     = 2;
  localparam int PRIV_LO   = 3;
  localparam int VPRIV_LO  = 23;
  localparam int SIZE_LO   = 16;
  localparam int KIND_LO   = 28;
  localparam int CTX_CHK   = 2;
  localparam int CTX_VAL_LO = 3;

  typedef enum logic [3:0] {
    KIND_BASIC = 4'd2,
    KIND_EXT   = 4'd6
  } kind_e;

  function automatic logic [3:0] window_bytes(input logic ext, input logic [CW-1:0] c);
    logic [3:0] code;
    code = ext ? c[SIZE_LO +: 4] : {2'b00, c[SIZE_LO +: 2]};
    case (code)
      4'd1:    return 4'd1;
      4'd2:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/amt_qualify.sv
`timescale 1ns/1ps
module amt_qualify
  import amt_pkg::*;
#(
  parameter int CTX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    ctrl,
  input  logic [CW-1:0]    ctx,
  input  logic [CTX_W-1:0] mctx,
  input  logic [1:0]       priv,
  input  logic             virt,
  output logic             arm_ex,
  output logic             arm_ld,
  output logic             arm_st,
  output logic [3:0]       win_bytes
);
  logic [3:0] kind;
  logic       is_basic, is_ext;
  logic       any_mode, any_op, priv_ok, ctx_ok, qual;
  logic [4:0] nv_idx, v_idx;
  logic       ctrl_unused, ctx_unused;

  assign kind     = ctrl[KIND_LO +: 4];
  assign is_basic = (kind == KIND_BASIC);
  assign is_ext   = (kind == KIND_EXT);

  assign nv_idx = 5'(PRIV_LO)  + {3'b000, priv};
  assign v_idx  = 5'(VPRIV_LO) + {3'b000, priv};

  always_comb begin
    any_mode = ctrl[PRIV_LO] | ctrl[PRIV_LO+1] | ctrl[PRIV_LO+3];
    if (is_ext) any_mode = any_mode | ctrl[VPRIV_LO] | ctrl[VPRIV_LO+1];
    any_op = |ctrl[OP_EX:OP_LD];
    if (virt) priv_ok = is_ext & ctrl[v_idx];
    else      priv_ok = ctrl[nv_idx];
    ctx_ok = !ctx[CTX_CHK] || (ctx[CTX_VAL_LO +: CTX_W] == mctx);
    qual   = (is_basic | is_ext) & any_mode & any_op & priv_ok & ctx_ok;
  end

  assign arm_ex    = qual & ctrl[OP_EX];
  assign arm_ld    = qual & ctrl[OP_LD];
  assign arm_st    = qual & ctrl[OP_ST];
  assign win_bytes = window_bytes(is_ext, ctrl);

  assign ctrl_unused = ^ctrl;
  assign ctx_unused  = ^ctx;

  AST_BASIC_VIRT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (virt && kind == KIND_BASIC) |-> !(arm_ex || arm_ld || arm_st)); // R3
endmodule

// File: rtl/amt_match.sv
`timescale 1ns/1ps
module amt_match #(
  parameter int XLEN = 32
) (
  input  logic            arm_ex,
  input  logic            arm_ld,
  input  logic            arm_st,
  input  logic [3:0]      win_bytes,
  input  logic [XLEN-1:0] cmp,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic            fetch_vld,
  input  logic [XLEN-1:0] mem_addr,
  input  logic            mem_ld,
  input  logic            mem_st,
  input  logic [1:0]      mem_size,
  output logic            ex_hit,
  output logic            mem_hit
);
  localparam int EW = XLEN + 1;
  logic [3:0]    acc_bytes;
  logic [EW-1:0] a_lo, a_hi, c_lo, c_hi;
  logic          overlap;

  assign acc_bytes = 4'd1 << mem_size;
  assign a_lo = {1'b0, mem_addr};
  assign c_lo = {1'b0, cmp};
  assign a_hi = a_lo + EW'(acc_bytes) - EW'(1);
  assign c_hi = c_lo + EW'(win_bytes) - EW'(1);
  assign overlap = (a_lo <= c_hi) && (c_lo <= a_hi);

  assign ex_hit  = arm_ex & fetch_vld & (fetch_pc == cmp);
  assign mem_hit = overlap & ((arm_ld & mem_ld) | (arm_st & mem_st));
endmodule

// File: rtl/amt_pick.sv
`timescale 1ns/1ps
module amt_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0))); // R9
endmodule

// File: rtl/amt_trigger_match.sv
`timescale 1ns/1ps
module amt_trigger_match
  import amt_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32,
  parameter int CTX_W    = 16,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_TRIG*CW-1:0]   trig_ctrl,
  input  logic [NUM_TRIG*XLEN-1:0] trig_cmp,
  input  logic [NUM_TRIG*CW-1:0]   trig_ctx,
  input  logic [CTX_W-1:0]         mctx,
  input  logic [1:0]               priv,
  input  logic                     virt,
  input  logic [XLEN-1:0]          fetch_pc,
  input  logic                     fetch_vld,
  input  logic [XLEN-1:0]          mem_addr,
  input  logic                     mem_ld,
  input  logic                     mem_st,
  input  logic [1:0]               mem_size,
  output logic                     bp_req,
  output logic [IDX_W-1:0]         bp_idx,
  output logic [XLEN-1:0]          bp_addr
);
  logic [NUM_TRIG-1:0] ex_hit, mem_hit, hit_vec;
  logic                hit_any;
  logic [IDX_W-1:0]    hit_idx;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    logic       a_ex, a_ld, a_st;
    logic [3:0] wb;

    amt_qualify #(.CTX_W(CTX_W)) u_qual (
      .clk       (clk),
      .rst       (rst),
      .ctrl      (trig_ctrl[g*CW +: CW]),
      .ctx       (trig_ctx[g*CW +: CW]),
      .mctx      (mctx),
      .priv      (priv),
      .virt      (virt),
      .arm_ex    (a_ex),
      .arm_ld    (a_ld),
      .arm_st    (a_st),
      .win_bytes (wb)
    );

    amt_match #(.XLEN(XLEN)) u_match (
      .arm_ex    (a_ex),
      .arm_ld    (a_ld),
      .arm_st    (a_st),
      .win_bytes (wb),
      .cmp       (trig_cmp[g*XLEN +: XLEN]),
      .fetch_pc  (fetch_pc),
      .fetch_vld (fetch_vld),
      .mem_addr  (mem_addr),
      .mem_ld    (mem_ld),
      .mem_st    (mem_st),
      .mem_size  (mem_size),
      .ex_hit    (ex_hit[g]),
      .mem_hit   (mem_hit[g])
    );
  end

  assign hit_vec = ex_hit | mem_hit;

  amt_pick #(.N(NUM_TRIG)) u_pick (
    .clk (clk),
    .rst (rst),
    .req (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_req  <= 1'b0;
      bp_idx  <= '0;
      bp_addr <= '0;
    end else begin
      bp_req <= hit_any;
      if (hit_any) begin
        bp_idx  <= hit_idx;
        bp_addr <= ex_hit[hit_idx] ? fetch_pc : mem_addr;
      end
    end
  end

  AST_REQ_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    bp_req |-> $past(fetch_vld || mem_ld || mem_st)); // R10
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    bp_req |-> (int'(bp_idx) < NUM_TRIG)); // R9
  AST_EXEC_ADDR: assert property (@(posedge clk) disable iff (rst)
    (bp_req && $past(fetch_vld) && !$past(mem_ld || mem_st)) |-> (bp_addr == $past(fetch_pc))); // R5
endmodule

// File: tb/amt_trigger_match_bench.sv
`timescale 1ns/1ps
module amt_trigger_match_bench;
  localparam int N  = 4;
  localparam int XL = 32;
  localparam int CX = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N*32-1:0] trig_ctrl = '0;
  logic [N*XL-1:0] trig_cmp  = '0;
  logic [N*32-1:0] trig_ctx  = '0;
  logic [CX-1:0]   mctx = '0;
  logic [1:0]      priv = 2'd3;
  logic            virt = 1'b0;
  logic [XL-1:0]   fetch_pc = '0;
  logic            fetch_vld = 1'b0;
  logic [XL-1:0]   mem_addr = '0;
  logic            mem_ld = 1'b0;
  logic            mem_st = 1'b0;
  logic [1:0]      mem_size = 2'd0;
  logic            bp_req;
  logic [1:0]      bp_idx;
  logic [XL-1:0]   bp_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  amt_trigger_match #(.NUM_TRIG(N), .XLEN(XL), .CTX_W(CX)) u_amt_trigger_match (
    .clk(clk), .rst(rst), .trig_ctrl(trig_ctrl), .trig_cmp(trig_cmp), .trig_ctx(trig_ctx),
    .mctx(mctx), .priv(priv), .virt(virt), .fetch_pc(fetch_pc), .fetch_vld(fetch_vld),
    .mem_addr(mem_addr), .mem_ld(mem_ld), .mem_st(mem_st), .mem_size(mem_size),
    .bp_req(bp_req), .bp_idx(bp_idx), .bp_addr(bp_addr)
  );

  function automatic logic [31:0] mk(input int kind, input logic [4:0] m,
                                     input logic [2:0] ops, input int code);
    logic [31:0] c;
    c = '0;
    c[31:28] = 4'(kind);
    c[3] = m[0]; c[4] = m[1]; c[6] = m[2]; c[23] = m[3]; c[24] = m[4];
    c[2:0] = ops;
    c[19:16] = 4'(code);
    return c;
  endfunction

  task automatic chk(input string r, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, got, exp);
    end
  endtask

  task automatic step(input string r, input bit er, input int ei, input logic [31:0] ea);
    logic [63:0] got, exp;
    @(negedge clk);
    got = er ? {29'd0, bp_req, bp_idx, bp_addr} : {29'd0, bp_req, 34'd0};
    exp = {29'd0, er, er ? 2'(ei) : 2'd0, er ? ea : 32'd0};
    chk(r, got, exp);
    fetch_vld = 1'b0; mem_ld = 1'b0; mem_st = 1'b0;
  endtask

  task automatic clear_trigs();
    trig_ctrl = '0; trig_cmp = '0; trig_ctx = '0; mctx = '0;
    fetch_vld = 1'b0; mem_ld = 1'b0; mem_st = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int kinds[4] = '{2, 6, 0, 5};
    // R10: reset clears outputs even with a hitting input
    trig_ctrl[31:0] = mk(2, 5'b00100, 3'b100, 0);
    trig_cmp[31:0]  = 32'h40;
    fetch_pc = 32'h40; fetch_vld = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset", {29'd0, bp_req, bp_idx, bp_addr}, 64'd0);
    rst = 1'b0;
    step("R10 first hit after reset", 1'b1, 0, 32'h40);
    step("R10 pulse ends without strobe", 1'b0, 0, 0);

    // R1 R2 R3 R4 R6 sweep over kind, virt, priv, enables, ops, access type
    for (int ki = 0; ki < 4; ki++)
      for (int v = 0; v < 2; v++)
        for (int p = 0; p < 4; p++)
          for (int m = 0; m < 32; m++)
            for (int o = 0; o < 8; o++)
              for (int k = 0; k < 3; k++) begin
                bit pok, e;
                logic [4:0] mb;
                logic [2:0] ob;
                mb = 5'(m); ob = 3'(o);
                clear_trigs();
                trig_ctrl[31:0] = mk(kinds[ki], mb, ob, 0);
                trig_cmp[31:0]  = 32'h1000;
                virt = 1'(v); priv = 2'(p);
                if (v == 1) pok = (kinds[ki] == 6) && ((p == 0 && mb[3]) || (p == 1 && mb[4]));
                else        pok = (p == 0 && mb[0]) || (p == 1 && mb[1]) || (p == 3 && mb[2]);
                e = (kinds[ki] == 2 || kinds[ki] == 6) && pok && ob[k];
                if (k == 2) begin fetch_pc = 32'h1000; fetch_vld = 1'b1; end
                else begin
                  mem_addr = 32'h1000; mem_size = 2'd2;
                  if (k == 0) mem_ld = 1'b1; else mem_st = 1'b1;
                end
                step("R1 R2 R3 R4 R6 sweep", e, 0, 32'h1000);
              end
    virt = 1'b0; priv = 2'd3;

    // R5: execute needs exact address equality
    for (int d = -4; d <= 4; d++) begin
      clear_trigs();
      trig_ctrl[31:0] = mk(6, 5'b00100, 3'b100, 0);
      trig_cmp[31:0]  = 32'h2000;
      fetch_pc = 32'(32'h2000 + d); fetch_vld = 1'b1;
      step("R5 exec exact match", d == 0, 0, 32'h2000);
    end

    // R7: window overlap sweep
    for (int t = 0; t < 2; t++)
      for (int code = 0; code < (t == 0 ? 4 : 16); code++)
        for (int a = 32'h1F8; a <= 32'h208; a++)
          for (int sz = 0; sz < 3; sz++) begin
            int wb, ab;
            bit e;
            clear_trigs();
            trig_ctrl[31:0] = mk(t == 0 ? 2 : 6, 5'b00100, 3'b001, code);
            trig_cmp[31:0]  = 32'h200;
            wb = (code == 1) ? 1 : (code == 2) ? 2 : 4;
            ab = 1 << sz;
            e = (a <= 32'h200 + wb - 1) && (32'h200 <= a + ab - 1);
            mem_addr = 32'(a); mem_size = 2'(sz); mem_ld = 1'b1;
            step("R7 window overlap", e, 0, 32'(a));
          end

    // R8: context qualifier
    for (int sel = 0; sel < 8; sel++)
      for (int eq = 0; eq < 2; eq++) begin
        clear_trigs();
        trig_ctrl[31:0] = mk(2, 5'b00100, 3'b100, 0);
        trig_cmp[31:0]  = 32'h300;
        trig_ctx[31:0]  = (32'h1234 << 3) | 32'(sel);
        mctx = (eq == 1) ? 16'h1234 : 16'h1235;
        fetch_pc = 32'h300; fetch_vld = 1'b1;
        step("R8 context select", (sel < 4) || (eq == 1), 0, 32'h300);
      end

    // R9: lowest index wins
    for (int lo = 0; lo <= N; lo++) begin
      clear_trigs();
      for (int i = 0; i < N; i++) begin
        trig_ctrl[i*32 +: 32] = (i < lo) ? 32'd0 : mk(2, 5'b00100, 3'b100, 0);
        trig_cmp[i*32 +: 32]  = 32'h40;
      end
      fetch_pc = 32'h40; fetch_vld = 1'b1;
      step("R9 lowest index", lo < N, lo, 32'h40);
    end
    clear_trigs();
    trig_ctrl[31:0] = mk(2, 5'b00100, 3'b001, 0); trig_cmp[31:0]  = 32'h80;
    trig_ctrl[63:32] = mk(2, 5'b00100, 3'b100, 0); trig_cmp[63:32] = 32'h40;
    fetch_pc = 32'h40; fetch_vld = 1'b1;
    mem_addr = 32'h80; mem_size = 2'd0; mem_ld = 1'b1;
    step("R9 data hit on lower index", 1'b1, 0, 32'h80);
    clear_trigs();
    trig_ctrl[63:32] = mk(6, 5'b00100, 3'b101, 0); trig_cmp[63:32] = 32'h40;
    fetch_pc = 32'h40; fetch_vld = 1'b1;
    mem_addr = 32'h3E; mem_size = 2'd2; mem_ld = 1'b1;
    step("R9 exec before data", 1'b1, 1, 32'h40);

    // R10: one pulse per strobe, back-to-back strobes give back-to-back pulses
    clear_trigs();
    trig_ctrl[31:0] = mk(2, 5'b00100, 3'b010, 0); trig_cmp[31:0] = 32'h500;
    mem_addr = 32'h500; mem_size = 2'd1; mem_st = 1'b1;
    step("R10 store pulse", 1'b1, 0, 32'h500);
    mem_addr = 32'h4FF; mem_size = 2'd1; mem_st = 1'b1;
    step("R10 second store pulse", 1'b1, 0, 32'h4FF);
    step("R10 idle after pulse", 1'b0, 0, 0);

    summary();
    $finish;
  end
endmodule